// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display link. A horizontal counter steps once per pixel clock through a programmable line period. Next to it runs a single flat position counter that walks the whole frame in pixel clocks. Every vertical quantity is written as an absolute pixel-clock position in the frame (line number times line period, plus any skew), not as a line number. These include the vsync length, the display-window bounds and the optional active sub-window bounds. From the two counters the block derives hsync, vsync and data-enable, each with its own polarity bit. It also emits a one-clock fetch-start pulse at a programmed frame position.

Inside the display window the block requests pixels with a valid/ready handshake. It passes each pixel through when one is offered and substitutes an underflow colour when none is, counting each such event. When an active sub-window is enabled, display-window pixels that fall outside it take a border colour instead. Software configures the block through a 32-bit write port with a combinational read-back. The timing registers are copied into a working set only while the engine is off or at the last clock of a frame, so a reprogrammed mode starts cleanly on the next frame.

Top module: `disp_timing_engine`

## Requirements
- R1: After reset all registers read 0 and hsync, vsync, de, fetch_pulse and pix_out are 0. A register written at byte address A (ENABLE 0x00, CONFIG 0x04, HTIMING 0x08, VTOTAL 0x0C, VSYNC_LEN 0x10, DISP_VFIRST 0x14, DISP_VLAST 0x18, DISP_HSPAN 0x1C, SUB_HSPAN 0x20, SUB_VFIRST 0x24, SUB_VLAST 0x28, BORDER 0x2C, UNDERFLOW 0x30, POLARITY 0x34, COUNT_EN 0x38, FETCH_POS 0x3C) reads back at A. FRAMES 0x40, LINES 0x44 and UF_EVENTS 0x48 are read-only.
- R2: With ENABLE bit 0 set, the horizontal counter runs 0 to HTIMING[31:16]-1 and wraps. Raw hsync is active while the counter is below HTIMING[15:0].
- R3: The frame position counts 0 to VTOTAL-1 in pixel clocks and then wraps to 0, which also restarts the horizontal counter. Raw vsync is active while the position is below VSYNC_LEN.
- R4: Raw de is active when DISP_VFIRST ≤ position ≤ DISP_VLAST and DISP_HSPAN[15:0] ≤ x ≤ DISP_HSPAN[31:16], with both bounds inclusive.
- R5: POLARITY bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts de at the outputs.
- R6: While ENABLE bit 0 is clear, both counters and the line counter are held at 0 and the raw syncs, de and fetch_pulse are inactive. Re-enabling starts at frame position 0.
- R7: CONFIG bit 29 limits the active region horizontally to SUB_HSPAN[15:0]..SUB_HSPAN[31:16]. CONFIG bit 30 limits it vertically to the positions SUB_VFIRST..SUB_VLAST. Each limit is ignored when its end value is 0. Display-window pixels outside the active region output BORDER.
- R8: In the active region pix_in_ready is 1. pix_out equals pix_in when pix_in_valid is 1 and equals UNDERFLOW otherwise, and each such clock increments UF_EVENTS. Outside the display window pix_out is 0.
- R9: When CONFIG bit 31 is set, fetch_pulse is 1 for the single clock in which the frame position equals FETCH_POS.
- R10: FRAMES increments at each frame wrap when COUNT_EN bit 0 is set. LINES returns to 0 at each frame wrap and increments at each horizontal wrap when COUNT_EN bit 1 is set.
- R11: The timing registers (CONFIG, HTIMING, VTOTAL, VSYNC_LEN, DISP_*, SUB_*) take effect only while disabled or from the next frame start. A write during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| pix_in | input | PW | Incoming pixel |
| pix_in_valid | input | 1 | Incoming pixel is present |
| pix_in_ready | output | 1 | Block consumes a pixel this clock |
| pix_out | output | PW | Outgoing pixel or substitute colour |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| fetch_pulse | output | 1 | One-clock fetch-start strobe |

## Verification
A wrong line counter or a missing wrap shows at hsync within one line period. A wrong flat position shows at vsync, de or fetch_pulse no later than the next programmed boundary, and in the worst case one frame later as a second fetch pulse at the wrong clock. A working register that is reloaded at the wrong moment shows as a changed hsync width inside the frame in which the write happened. Sub-window and substitution faults show immediately on pix_out and pix_in_ready at the first pixel of the affected span.

// File: rtl/disp_timing_engine.sv
module disp_timing_engine #(
  parameter int PW = 24,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [PW-1:0] pix_in,
  input  logic          pix_in_valid,
  output logic          pix_in_ready,
  output logic [PW-1:0] pix_out,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          fetch_pulse
);
  localparam logic [AW-1:0] A_EN = AW'(8'h00), A_CFG = AW'(8'h04), A_HT = AW'(8'h08),
    A_VT = AW'(8'h0C), A_VSL = AW'(8'h10), A_DVF = AW'(8'h14), A_DVL = AW'(8'h18),
    A_DH = AW'(8'h1C), A_SH = AW'(8'h20), A_SVF = AW'(8'h24), A_SVL = AW'(8'h28),
    A_BRD = AW'(8'h2C), A_UFC = AW'(8'h30), A_POL = AW'(8'h34), A_CEN = AW'(8'h38),
    A_FP = AW'(8'h3C), A_FRM = AW'(8'h40), A_LIN = AW'(8'h44), A_UFN = AW'(8'h48);
  localparam int ZP = 32 - PW;

  logic          en;
  logic [2:0]    cfg, pol;
  logic [1:0]    cnt_en;
  logic [31:0]   ht, vt, vsl, dvf, dvl, dh, sh, svf, svl, fpos;
  logic [PW-1:0] brd, ufc;
  logic [2:0]    s_cfg;
  logic [31:0]   s_ht, s_vt, s_vsl, s_dvf, s_dvl, s_dh, s_sh, s_svf, s_svl;
  logic [15:0]   hcnt;
  logic [31:0]   pos, frames, lines, uf_events;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; cfg <= '0; pol <= '0; cnt_en <= '0;
      ht <= '0; vt <= '0; vsl <= '0; dvf <= '0; dvl <= '0; dh <= '0;
      sh <= '0; svf <= '0; svl <= '0; fpos <= '0; brd <= '0; ufc <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN:  en <= reg_wdata[0];
        A_CFG: cfg <= reg_wdata[31:29];
        A_HT:  ht <= reg_wdata;
        A_VT:  vt <= reg_wdata;
        A_VSL: vsl <= reg_wdata;
        A_DVF: dvf <= reg_wdata;
        A_DVL: dvl <= reg_wdata;
        A_DH:  dh <= reg_wdata;
        A_SH:  sh <= reg_wdata;
        A_SVF: svf <= reg_wdata;
        A_SVL: svl <= reg_wdata;
        A_BRD: brd <= reg_wdata[PW-1:0];
        A_UFC: ufc <= reg_wdata[PW-1:0];
        A_POL: pol <= reg_wdata[2:0];
        A_CEN: cnt_en <= reg_wdata[1:0];
        A_FP:  fpos <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_EN:  reg_rdata = {31'd0, en};
      A_CFG: reg_rdata = {cfg, 29'd0};
      A_HT:  reg_rdata = ht;
      A_VT:  reg_rdata = vt;
      A_VSL: reg_rdata = vsl;
      A_DVF: reg_rdata = dvf;
      A_DVL: reg_rdata = dvl;
      A_DH:  reg_rdata = dh;
      A_SH:  reg_rdata = sh;
      A_SVF: reg_rdata = svf;
      A_SVL: reg_rdata = svl;
      A_BRD: reg_rdata = {{ZP{1'b0}}, brd};
      A_UFC: reg_rdata = {{ZP{1'b0}}, ufc};
      A_POL: reg_rdata = {29'd0, pol};
      A_CEN: reg_rdata = {30'd0, cnt_en};
      A_FP:  reg_rdata = fpos;
      A_FRM: reg_rdata = frames;
      A_LIN: reg_rdata = lines;
      A_UFN: reg_rdata = uf_events;
      default: reg_rdata = '0;
    endcase
  end

  wire frame_end = en && (pos == s_vt - 32'd1);
  wire line_end  = hcnt == s_ht[31:16] - 16'd1;
  wire load      = !en || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_cfg <= '0; s_ht <= '0; s_vt <= '0; s_vsl <= '0; s_dvf <= '0;
      s_dvl <= '0; s_dh <= '0; s_sh <= '0; s_svf <= '0; s_svl <= '0;
    end else if (load) begin
      s_cfg <= cfg; s_ht <= ht; s_vt <= vt; s_vsl <= vsl; s_dvf <= dvf;
      s_dvl <= dvl; s_dh <= dh; s_sh <= sh; s_svf <= svf; s_svl <= svl;
    end
  end

  wire hs_raw = en && (hcnt < s_ht[15:0]);
  wire vs_raw = en && (pos < s_vsl);
  wire disp   = en && (pos >= s_dvf) && (pos <= s_dvl) &&
                (hcnt >= s_dh[15:0]) && (hcnt <= s_dh[31:16]);
  wire sub_h  = !(s_cfg[0] && s_sh[31:16] != 16'd0) ||
                ((hcnt >= s_sh[15:0]) && (hcnt <= s_sh[31:16]));
  wire sub_v  = !(s_cfg[1] && s_svl != 32'd0) || ((pos >= s_svf) && (pos <= s_svl));
  wire active = disp && sub_h && sub_v;

  assign hsync        = hs_raw ^ pol[0];
  assign vsync        = vs_raw ^ pol[1];
  assign de           = disp ^ pol[2];
  assign fetch_pulse  = en && s_cfg[2] && (pos == fpos);
  assign pix_in_ready = active;
  assign pix_out      = !disp ? '0 : !active ? brd : pix_in_valid ? pix_in : ufc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0; pos <= '0; frames <= '0; lines <= '0; uf_events <= '0;
    end else begin
      if (!en) begin
        hcnt <= '0; pos <= '0; lines <= '0;
      end else if (frame_end) begin
        hcnt <= '0; pos <= '0; lines <= '0;
        if (cnt_en[0]) frames <= frames + 32'd1;
      end else begin
        pos <= pos + 32'd1;
        if (line_end) begin
          hcnt <= '0;
          if (cnt_en[1]) lines <= lines + 32'd1;
        end else hcnt <= hcnt + 16'd1;
      end
      if (active && !pix_in_valid) uf_events <= uf_events + 32'd1;
    end
  end

  p_hcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s_ht[31:16] != 16'd0) |-> hcnt < s_ht[31:16]);
  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s_vt != 32'd0) |-> pos < s_vt);
  p_idle_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (hsync == pol[0] && vsync == pol[1] && !fetch_pulse));
  p_ready_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_ready |-> (de != pol[2]));
  p_fetch_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_pulse && s_vt > 32'd1 && !reg_wr) |=> !fetch_pulse);
  p_frame_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cnt_en[0]) |=> frames == $past(frames) + 32'd1);
  p_line_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> lines == 32'd0);
  p_hold_shadow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> $stable(s_ht));
endmodule

// File: tb/disp_timing_engine_test.sv
`timescale 1ns/1ps
module disp_timing_engine_test;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, pix_in_valid = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [23:0] pix_in = 24'hABCDEF, pix_out;
  logic pix_in_ready, hsync, vsync, de, fetch_pulse;
  int checks = 0, errors = 0, k = 0;
  logic [31:0] fc0;

  always #2.5 clk = ~clk;

  disp_timing_engine uut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .pix_in, .pix_in_valid, .pix_in_ready, .pix_out, .hsync, .vsync, .de, .fetch_pulse);

  // {cycle since enable, hsync, vsync, de, fetch}
  localparam logic [11:0] VEC [16] = '{
    {8'd0, 4'b1100}, {8'd1, 4'b1100}, {8'd2, 4'b0100}, {8'd5, 4'b0101},
    {8'd6, 4'b0100}, {8'd9, 4'b0100}, {8'd10, 4'b1000}, {8'd20, 4'b1000},
    {8'd24, 4'b0010}, {8'd27, 4'b0010}, {8'd28, 4'b0000}, {8'd44, 4'b0010},
    {8'd47, 4'b0010}, {8'd54, 4'b0000}, {8'd60, 4'b1100}, {8'd65, 4'b0101}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %h expected %h", req, k, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); k++;
  endtask

  task automatic go_to(input int t);
    while (k < t) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic enable();
    wr(8'h00, 32'd1); k = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0); chk("R1 de", de, 0);
    chk("R1 fetch", fetch_pulse, 0); chk("R1 pix_out", pix_out, 0);
    rst_n = 1'b1;
    step();
    rd(8'h00, rv); chk("R1 enable reset", rv, 0);
    rd(8'h1C, rv); chk("R1 hspan reset", rv, 0);
    // line 10 clocks: sync 2, back 2, width 4, front 2; 6 lines: sync 1, back 1, height 3, front 1
    wr(8'h08, 32'h000A_0002); wr(8'h0C, 32'd60); wr(8'h10, 32'd10);
    wr(8'h14, 32'd20); wr(8'h18, 32'd49); wr(8'h1C, 32'h0007_0004);
    wr(8'h04, 32'h8000_0000); wr(8'h3C, 32'd5); wr(8'h2C, 32'h00FF00);
    wr(8'h30, 32'h0000FF); wr(8'h38, 32'd3);
    rd(8'h1C, rv); chk("R1 readback hspan", rv, 32'h0007_0004);
    rd(8'h04, rv); chk("R1 readback config", rv, 32'h8000_0000);
    enable();
    foreach (VEC[i]) begin
      go_to(int'(VEC[i][11:4]));
      chk("R2 hsync", hsync, VEC[i][3]);
      chk("R3 vsync", vsync, VEC[i][2]);
      chk("R4 de", de, VEC[i][1]);
      chk("R9 fetch", fetch_pulse, VEC[i][0]);
    end
    rd(8'h40, rv); chk("R10 frames after one wrap", rv, 1);
    rd(8'h44, rv); chk("R10 lines restart", rv, 0);
    // R8 pass-through and underflow substitution
    go_to(84);
    chk("R8 pass pixel", pix_out, 24'hABCDEF); chk("R8 ready", pix_in_ready, 1);
    pix_in_valid = 1'b0; #0.1;
    chk("R8 underflow colour", pix_out, 24'h0000FF);
    step(); pix_in_valid = 1'b1;
    rd(8'h48, rv); chk("R8 underflow count", rv, 1);
    rd(8'h44, rv); chk("R10 line count", rv, 2);
    go_to(90); chk("R8 outside window zero", pix_out, 0);
    // R11 mid-frame change of hsync width
    wr(8'h08, 32'h000A_0005);
    go_to(92); chk("R11 old width kept", hsync, 0);
    go_to(122); chk("R11 new width", hsync, 1);
    go_to(124); chk("R11 new width end", hsync, 1);
    go_to(125); chk("R11 new width off", hsync, 0);
    // R6 disable
    wr(8'h00, 32'd0);
    chk("R6 hsync idle", hsync, 0); chk("R6 vsync idle", vsync, 0); chk("R6 de idle", de, 0);
    rd(8'h44, rv); chk("R6 lines cleared", rv, 0);
    // R5 polarity
    wr(8'h34, 32'd7);
    chk("R5 hsync inv", hsync, 1); chk("R5 vsync inv", vsync, 1); chk("R5 de inv", de, 1);
    wr(8'h34, 32'd0);
    // R7 sub-window: x 5..6, positions 30..39
    wr(8'h08, 32'h000A_0002); wr(8'h20, 32'h0006_0005);
    wr(8'h24, 32'd30); wr(8'h28, 32'd39); wr(8'h04, 32'hE000_0000);
    enable();
    go_to(25); chk("R7 border outside v", pix_out, 24'h00FF00); chk("R7 ready low", pix_in_ready, 0);
    go_to(34); chk("R7 border left", pix_out, 24'h00FF00); chk("R7 de in border", de, 1);
    go_to(35); chk("R7 inside", pix_out, 24'hABCDEF);
    go_to(36); chk("R7 inside end", pix_out, 24'hABCDEF);
    go_to(37); chk("R7 border right", pix_out, 24'h00FF00);
    go_to(45); chk("R7 border below", pix_out, 24'h00FF00);
    // R7 zero end disables the limits
    wr(8'h00, 32'd0); wr(8'h20, 32'd0); wr(8'h28, 32'd0);
    enable();
    go_to(24); chk("R7 zero end ignored", pix_out, 24'hABCDEF);
    // R10 counting disabled
    wr(8'h00, 32'd0); wr(8'h38, 32'd0);
    rd(8'h40, fc0);
    enable();
    go_to(85);
    rd(8'h40, rv); chk("R10 frames held", rv, fc0);
    rd(8'h44, rv); chk("R10 lines held", rv, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule